// File: doc/BRIEF.md
# Width-Selectable ALU With Flags

This block is the arithmetic and logic stage of a small 32-bit processor. Every operation arrives with a width code that narrows it to a byte, a halfword or a full word. The first operand comes from a register. The second comes either from a register or from an immediate field, and a select input picks between them. Both operands are cut down to the chosen width before the operation. The result is zero-extended back to 32 bits. The zero, negative, carry and overflow flags describe the narrow result, not the full word.

The datapath between the operand inputs and the result is purely combinational. Its result and flags are captured into an output register on each rising clock edge, which plays the part of the execute-stage latch. A decoder drives the opcode, width, operands and immediate. The retire logic reads the registered result and flags one cycle later.

Top module: `wsel_alu`

## Requirements
- R1: The 3-bit opcode selects the operation: 0 adds, 1 subtracts (A minus second operand), 2 is bitwise AND, 3 is bitwise OR, 4 is bitwise XOR, and 5, 6 and 7 pass the second operand through unchanged.
- R2: The 2-bit width code selects the operation size: 00 is 8 bits, 01 is 16 bits, and both 10 and 11 are 32 bits. Operand bits above the selected width have no effect on the result or the flags.
- R3: Result bits above the selected width are always zero, so a narrow result is zero-extended.
- R4: When the immediate select input is 1, the immediate (zero-extended to 32 bits, then masked to the width) is the second operand, and operand B has no effect. When it is 0, operand B is the second operand.
- R5: The zero flag is 1 exactly when the width-limited result is zero.
- R6: The negative flag equals the most significant bit of the selected width of the result (bit 7, 15 or 31).
- R7: For add, carry is the carry out of the selected width. For subtract, carry is set when a borrow occurs, that is, when the masked A is below the masked second operand as unsigned numbers. A byte subtract of 1 minus 1 therefore gives 0x00000000 with zero set and negative, carry and overflow clear.
- R8: For add and subtract, the overflow flag is the signed two's-complement overflow at the selected width.
- R9: For AND, OR, XOR and pass, carry and overflow are zero.
- R10: Result and flags appear on the outputs at the rising clock edge after the inputs are applied. A synchronous active-high reset clears the result and all four flags to zero at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code |
| width_i | input | 2 | Width code |
| src_a_i | input | 32 | Register operand A |
| src_b_i | input | 32 | Register operand B |
| imm_i | input | IMM_W (16) | Immediate field, zero-extended |
| imm_sel_i | input | 1 | 1 selects the immediate as the second operand |
| result_o | output | 32 | Registered, zero-extended result |
| zero_o | output | 1 | Registered zero flag |
| neg_o | output | 1 | Registered negative flag |
| carry_o | output | 1 | Registered carry/borrow flag |
| ovf_o | output | 1 | Registered signed overflow flag |

## Verification
The operand patterns are chosen so that a fault in one width lane or one flag shows up on its own.

- **Junk in upper bits:** operands carry nonzero bits above the selected width. This tells proper masking apart from arithmetic done on the full word.
- **Boundary values at each width:** 0x7F+1, 0x80-1, 0xFF+1, 0x7FFF+1, 0x0-1 and 0x80000000-1. These separate carry from overflow and make the negative flag follow bit 7, 15 or 31 as the width requires.
- **Immediate select:** paired vectors change only operand B while the immediate is selected. This shows that the multiplexer drops B.
- **Random sweep:** a random sweep over all opcodes and width codes is compared each clock against a behavioural model.

// File: rtl/wsel_alu_pkg.sv
package wsel_alu_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_PASS = 3'd5
    } alu_op_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WRD2 = 2'b11
    } alu_size_t;

    typedef struct packed {
        logic zero;
        logic neg;
        logic carry;
        logic ovf;
    } alu_flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        alu_flags_t        flags;
    } alu_out_t;

    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_mask = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
            SZ_HALF: size_mask = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
            default: size_mask = {DATA_W{1'b1}};
        endcase
    endfunction

    function automatic logic size_msb(input logic [1:0] sz, input logic [DATA_W-1:0] v);
        case (sz)
            SZ_BYTE: size_msb = v[BYTE_W-1];
            SZ_HALF: size_msb = v[HALF_W-1];
            default: size_msb = v[DATA_W-1];
        endcase
    endfunction

    function automatic logic is_arith(input logic [2:0] op);
        is_arith = (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/wsel_operand_sel.sv
module wsel_operand_sel
    import wsel_alu_pkg::*;
#(
    parameter int IMM_W = 16
) (
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] reg_a_i,
    input  logic [DATA_W-1:0] reg_b_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              imm_sel_i,
    output logic [DATA_W-1:0] opa_o,
    output logic [DATA_W-1:0] opb_o
);
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] second;

    generate
        if (IMM_W < DATA_W) begin : g_imm_pad
            assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm_i};
        end else begin : g_imm_cut
            assign imm_ext = imm_i[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        mask   = size_mask(size_i);
        second = imm_sel_i ? imm_ext : reg_b_i;
        opa_o  = reg_a_i & mask;
        opb_o  = second & mask;
    end
endmodule

// File: rtl/wsel_alu_core.sv
module wsel_alu_core
    import wsel_alu_pkg::*;
(
    input  logic [2:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output alu_out_t          out_o
);
    localparam int NLANE = 3;
    localparam int LANE_W [NLANE] = '{BYTE_W, HALF_W, DATA_W};

    logic [DATA_W:0]   sum_x;
    logic [DATA_W:0]   dif_x;
    logic [DATA_W-1:0] raw;
    logic [NLANE-1:0]  lane_zero;
    logic [NLANE-1:0]  lane_cout;
    logic              sa, sb, sr;
    logic              carry_w, zero_w;

    assign sum_x = {1'b0, opa_i} + {1'b0, opb_i};
    assign dif_x = {1'b0, opa_i} - {1'b0, opb_i};

    always_comb begin
        case (op_i)
            OP_ADD:  raw = sum_x[DATA_W-1:0];
            OP_SUB:  raw = dif_x[DATA_W-1:0];
            OP_AND:  raw = opa_i & opb_i;
            OP_OR:   raw = opa_i | opb_i;
            OP_XOR:  raw = opa_i ^ opb_i;
            default: raw = opb_i;
        endcase
    end

    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_lane
            assign lane_zero[g] = ~|raw[LANE_W[g]-1:0];
            assign lane_cout[g] = sum_x[LANE_W[g]];
        end
    endgenerate

    always_comb begin
        case (size_i)
            SZ_BYTE: begin zero_w = lane_zero[0]; carry_w = lane_cout[0]; end
            SZ_HALF: begin zero_w = lane_zero[1]; carry_w = lane_cout[1]; end
            default: begin zero_w = lane_zero[2]; carry_w = lane_cout[2]; end
        endcase
        sa = size_msb(size_i, opa_i);
        sb = size_msb(size_i, opb_i);
        sr = size_msb(size_i, raw);
        out_o.value       = raw & size_mask(size_i);
        out_o.flags.zero  = zero_w;
        out_o.flags.neg   = sr;
        out_o.flags.carry = 1'b0;
        out_o.flags.ovf   = 1'b0;
        if (op_i == OP_ADD) begin
            out_o.flags.carry = carry_w;
            out_o.flags.ovf   = (sa == sb) && (sr != sa);
        end else if (op_i == OP_SUB) begin
            out_o.flags.carry = dif_x[DATA_W];
            out_o.flags.ovf   = (sa != sb) && (sr != sa);
        end
    end
endmodule

// File: rtl/wsel_out_reg.sv
module wsel_out_reg
    import wsel_alu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  alu_out_t d_i,
    output alu_out_t q_o
);
    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= d_i;
    end
endmodule

// File: rtl/wsel_alu.sv
module wsel_alu
    import wsel_alu_pkg::*;
#(
    parameter int IMM_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_i,
    input  logic [1:0]        width_i,
    input  logic [31:0]       src_a_i,
    input  logic [31:0]       src_b_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              imm_sel_i,
    output logic [31:0]       result_o,
    output logic              zero_o,
    output logic              neg_o,
    output logic              carry_o,
    output logic              ovf_o
);
    logic [DATA_W-1:0] opa, opb;
    alu_out_t          comb_out;
    alu_out_t          reg_out;

    wsel_operand_sel #(.IMM_W(IMM_W)) u_sel (
        .size_i    (width_i),
        .reg_a_i   (src_a_i),
        .reg_b_i   (src_b_i),
        .imm_i     (imm_i),
        .imm_sel_i (imm_sel_i),
        .opa_o     (opa),
        .opb_o     (opb)
    );

    wsel_alu_core u_core (
        .op_i   (op_i),
        .size_i (width_i),
        .opa_i  (opa),
        .opb_i  (opb),
        .out_o  (comb_out)
    );

    wsel_out_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d_i (comb_out),
        .q_o (reg_out)
    );

    assign result_o = reg_out.value;
    assign zero_o   = reg_out.flags.zero;
    assign neg_o    = reg_out.flags.neg;
    assign carry_o  = reg_out.flags.carry;
    assign ovf_o    = reg_out.flags.ovf;

    // R3
    byte_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (width_i == SZ_BYTE) |=> (result_o[31:8] == 24'd0));

    // R3
    half_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (width_i == SZ_HALF) |=> (result_o[31:16] == 16'd0));

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (zero_o == (result_o == 32'd0)));

    // R6
    byte_neg_chk: assert property (@(posedge clk) disable iff (rst)
        (width_i == SZ_BYTE) |=> (neg_o == result_o[7]));

    // R9
    logic_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !is_arith(op_i) |=> (!carry_o && !ovf_o));

    // R4
    imm_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_PASS && imm_sel_i && width_i == SZ_BYTE) |=> (result_o[7:0] == $past(imm_i[7:0])));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (result_o == 32'd0 && !zero_o && !neg_o && !carry_o && !ovf_o));
endmodule

// File: tb/test_wsel_alu.sv
`timescale 1ns/1ps
module test_wsel_alu;
    localparam int IMM_W = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic [2:0]        op;
    logic [1:0]        width;
    logic [31:0]       a, b;
    logic [IMM_W-1:0]  imm;
    logic              sel;
    logic [31:0]       result;
    logic              zf, nf, cf, vf;

    int checks = 0;
    int errors = 0;
    logic [35:0] exp_val;
    bit          exp_valid = 0;
    string       exp_tag;

    always #2.5 clk = ~clk;

    wsel_alu #(.IMM_W(IMM_W)) i_wsel_alu (
        .clk(clk), .rst(rst), .op_i(op), .width_i(width),
        .src_a_i(a), .src_b_i(b), .imm_i(imm), .imm_sel_i(sel),
        .result_o(result), .zero_o(zf), .neg_o(nf), .carry_o(cf), .ovf_o(vf)
    );

    function automatic logic [35:0] model(int o, int w, logic [31:0] xa, logic [31:0] xb,
                                           logic [IMM_W-1:0] xi, bit s);
        int n = (w == 0) ? 8 : (w == 1) ? 16 : 32;
        longint m = (longint'(1) <<< n) - 1;
        longint x = longint'(xa) & m;
        longint y = (s ? longint'(xi) : longint'(xb)) & m;
        longint r;
        bit c = 0, v = 0, sx, sy, sr;
        logic [31:0] r32;
        sx = x[n-1];
        sy = y[n-1];
        case (o)
            0: begin r = x + y; c = r[n]; r = r & m; sr = r[n-1]; v = (sx == sy) && (sr != sx); end
            1: begin c = (x < y); r = (x - y) & m; sr = r[n-1]; v = (sx != sy) && (sr != sx); end
            2: r = x & y;
            3: r = x | y;
            4: r = x ^ y;
            default: r = y;
        endcase
        r32 = r[31:0];
        sr = r32[n-1];
        return {r32, (r32 == 32'd0), sr, c, v};
    endfunction

    task automatic compare();
        if (exp_valid) begin
            checks++;
            if ({result, zf, nf, cf, vf} !== exp_val) begin
                errors++;
                $display("FAIL %s: got res=%h znc v=%b%b%b%b expected res=%h znc v=%b%b%b%b",
                         exp_tag, result, zf, nf, cf, vf,
                         exp_val[35:4], exp_val[3], exp_val[2], exp_val[1], exp_val[0]);
            end
        end
    endtask

    task automatic step(int o, int w, logic [31:0] xa, logic [31:0] xb,
                        logic [IMM_W-1:0] xi, bit s, bit r, string tag);
        @(negedge clk);
        compare();
        rst = r; op = o[2:0]; width = w[1:0]; a = xa; b = xb; imm = xi; sel = s;
        exp_val = r ? 36'd0 : model(o, w, xa, xb, xi, s);
        exp_tag = tag;
        exp_valid = 1;
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; op = 0; width = 0; a = 0; b = 0; imm = 0; sel = 0;
        // R10 reset state
        step(0, 2, 32'h1234, 32'h1, 0, 0, 1, "R10 reset");
        step(0, 2, 32'h1234, 32'h1, 0, 0, 1, "R10 reset");
        // R7 byte 1-1 with immediate
        step(1, 0, 32'h1, 32'hFFFF, 16'h1, 1, 0, "R7 sub.b 1-1");
        // R2 upper junk ignored
        step(0, 0, 32'hABCD_EF01, 32'h1234_5602, 0, 0, 0, "R2 add.b junk");
        step(0, 1, 32'hFFFF_0001, 32'h0F0F_0002, 0, 0, 0, "R2 add.h junk");
        step(3, 3, 32'h0000_F000, 32'h0F00_0000, 0, 0, 0, "R2 width code 11 word");
        // R8 overflow boundaries
        step(0, 0, 32'h7F, 32'h1, 0, 0, 0, "R8 add.b 7F+1");
        step(1, 0, 32'h80, 32'h1, 0, 0, 0, "R8 sub.b 80-1");
        step(0, 1, 32'h7FFF, 32'h1, 0, 0, 0, "R8 add.h 7FFF+1");
        step(1, 2, 32'h8000_0000, 32'h1, 0, 0, 0, "R8 sub.w min-1");
        // R7 carry
        step(0, 0, 32'hFF, 32'h1, 0, 0, 0, "R7 add.b FF+1");
        step(0, 2, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, "R7 add.w carry");
        step(1, 1, 32'h0, 32'h1, 0, 0, 0, "R7 sub.h borrow");
        // R6 negative per width
        step(5, 0, 0, 32'h0000_0080, 0, 0, 0, "R6 pass.b msb7");
        step(5, 1, 0, 32'h0000_8000, 0, 0, 0, "R6 pass.h msb15");
        step(5, 0, 0, 32'h0000_8000, 0, 0, 0, "R6 pass.b bit15 dropped");
        // R5 zero at narrow width
        step(0, 1, 32'h0001_8000, 32'h0000_8000, 0, 0, 0, "R5 add.h wraps to zero");
        // R9 logic ops
        step(2, 2, 32'hF0F0_F0F0, 32'hFF00_FF00, 0, 0, 0, "R9 and.w");
        step(4, 0, 32'hFF, 32'hFF, 0, 0, 0, "R9 xor.b zero");
        // R1 pass variants 6,7
        step(6, 2, 32'h1, 32'hDEAD_BEEF, 0, 0, 0, "R1 op6 pass");
        step(7, 1, 32'h1, 32'hDEAD_BEEF, 0, 0, 0, "R1 op7 pass");
        // R4 immediate replaces B: B changes, result must not
        step(0, 2, 32'h10, 32'h1111_1111, 16'hFFFF, 1, 0, "R4 imm b1");
        step(0, 2, 32'h10, 32'h2222_2222, 16'hFFFF, 1, 0, "R4 imm b2");
        step(5, 1, 32'h0, 32'h5555_5555, 16'h8001, 1, 0, "R4 pass imm");
        // R10 mid-run reset
        step(0, 2, 32'h5, 32'h6, 0, 0, 1, "R10 reset mid-run");
        // R1 random sweep
        for (int k = 0; k < 400; k++) begin
            int ro = $urandom_range(0, 7);
            int rw = $urandom_range(0, 3);
            step(ro, rw, $urandom, $urandom, IMM_W'($urandom), bit'($urandom_range(0, 1)), 0,
                 "R1 random");
        end
        @(negedge clk);
        compare();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule